// File: doc/BRIEF.md
# Rank-Aware Data Bus Turnaround Gap Unit

This block keeps, in clock cycles, the time at which a shared DRAM data bus becomes free, and inserts the idle gap that each new burst needs before it may use the bus. A scheduler pulses an issue strobe for each burst. With the strobe it gives the burst's rank, whether the burst is a write, and whether the command direction has just flipped.

The unit remembers the rank of the previous burst. It picks one of three gaps:
- a same-rank read-to-write penalty,
- a same-rank write-to-read penalty (write-to-read recovery plus CAS latency),
- a rank-to-rank penalty, which also replaces the same-rank penalty when a direction flip also changes rank.

The new burst then occupies the bus for one burst length after the gap. A free-running cycle count, the bus-free cycle, the active rank and a busy flag are exposed so the scheduler can hold off its next issue.

Top module: `bus_gap_unit`

## Requirements
- R1: After reset, the cycle count, the bus-free cycle and the active rank are all 0 and the busy flag is low.
- R2: The cycle count `nowCycle` advances by exactly 1 on every clock edge out of reset.
- R3: An issue with `typeSwitch`=0 to the active rank sets the bus-free cycle to max(bus-free, now) + T_BURST, adding no gap.
- R4: An issue with `typeSwitch`=0 to a rank other than the active rank adds the rank gap T_CS (default 2) before T_BURST.
- R5: An issue with `typeSwitch`=1, `issueWrite`=0 (write-to-read) to the active rank adds T_WTR + T_CL before T_BURST.
- R6: An issue with `typeSwitch`=1, `issueWrite`=1 (read-to-write) to the active rank adds T_RTW before T_BURST.
- R7: An issue with `typeSwitch`=1 to a rank other than the active rank adds only T_CS, for either direction.
- R8: After each issue the active rank equals that issue's rank; without an issue the active rank and the bus-free cycle do not change.
- R9: `busy` is high exactly when `nowCycle` is less than `busyUntil`.
- R10: When the bus is already free (bus-free cycle not above now), the new burst's gap counts from the current cycle, not from the stale bus-free value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | A burst is issued this cycle |
| issueRank | input | RANK_W | Rank of the issued burst |
| issueWrite | input | 1 | 1 = write burst, 0 = read burst |
| typeSwitch | input | 1 | Direction changed relative to the previous burst |
| nowCycle | output | TIME_W | Free-running cycle count since reset |
| busyUntil | output | TIME_W | First cycle at which the data bus is free |
| activeRank | output | RANK_W | Rank of the last issued burst |
| busy | output | 1 | Data bus is still occupied this cycle |

## Verification
The bench targets the corners where a gap choice can go wrong:
- A direction flip that also changes rank must take only the rank gap. A design that adds both penalties, or the same-rank one, shows a larger bus-free cycle.
- A read after a write must include the CAS latency. Dropping it shortens the gap by T_CL.
- Issues after a long idle period must count from the current cycle. A design that adds to the stale bus-free value reports a bus-free cycle in the past.
- Back-to-back issues while the bus is busy must stack from the bus-free value rather than from now.
- The active rank must follow each issue, or later same-rank bursts would be charged a spurious rank gap.

// File: rtl/bus_gap_pkg.sv
package bus_gap_pkg;

  typedef enum logic [1:0] {
    GAP_NONE = 2'd0,
    GAP_RANK = 2'd1,
    GAP_W2R  = 2'd2,
    GAP_R2W  = 2'd3
  } gapKind_e;

  typedef struct packed {
    logic     load;
    gapKind_e kind;
  } gapCtl_t;

endpackage

// File: rtl/bus_gap_ctrl.sv
module bus_gap_ctrl
  import bus_gap_pkg::*;
#(
  parameter int RANKS  = 4,
  localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [RANK_W-1:0] issueRank,
  input  logic              issueWrite,
  input  logic              typeSwitch,
  output gapCtl_t           ctl,
  output logic [RANK_W-1:0] activeRank
);

  logic rankChange;
  assign rankChange = (issueRank != activeRank);

  always_comb begin
    ctl.load = issueValid;
    ctl.kind = GAP_NONE;
    if (issueValid) begin
      if (rankChange)      ctl.kind = GAP_RANK;
      else if (typeSwitch) ctl.kind = issueWrite ? GAP_R2W : GAP_W2R;
      else                 ctl.kind = GAP_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           activeRank <= '0;
    else if (issueValid) activeRank <= issueRank;
  end

  // R8
  rank_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> activeRank == $past(issueRank));

  // R8
  rank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |=> $stable(activeRank));

  // R7
  switch_rank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && typeSwitch && rankChange) |-> ctl.kind == GAP_RANK);

endmodule

// File: rtl/bus_gap_datapath.sv
module bus_gap_datapath
  import bus_gap_pkg::*;
#(
  parameter int TIME_W  = 32,
  parameter int T_BURST = 4,
  parameter int T_CS    = 2,
  parameter int T_WTR   = 4,
  parameter int T_CL    = 5,
  parameter int T_RTW   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  gapCtl_t           ctl,
  output logic [TIME_W-1:0] nowCycle,
  output logic [TIME_W-1:0] busyUntil,
  output logic              busy
);

  localparam logic [TIME_W-1:0] BurstLen = TIME_W'(T_BURST);
  localparam logic [TIME_W-1:0] RankGap  = TIME_W'(T_CS);
  localparam logic [TIME_W-1:0] W2rGap   = TIME_W'(T_WTR + T_CL);
  localparam logic [TIME_W-1:0] R2wGap   = TIME_W'(T_RTW);

  logic [TIME_W-1:0] gapLen;
  logic [TIME_W-1:0] baseCycle;

  always_comb begin
    unique case (ctl.kind)
      GAP_RANK: gapLen = RankGap;
      GAP_W2R:  gapLen = W2rGap;
      GAP_R2W:  gapLen = R2wGap;
      default:  gapLen = '0;
    endcase
  end

  assign baseCycle = (busyUntil > nowCycle) ? busyUntil : nowCycle;
  assign busy      = (nowCycle < busyUntil);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nowCycle  <= '0;
      busyUntil <= '0;
    end else begin
      nowCycle <= nowCycle + 1'b1;
      if (ctl.load) busyUntil <= baseCycle + gapLen + BurstLen;
    end
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    $rose(rstN) |-> (nowCycle == '0 && busyUntil == '0));

  // R2
  cycle_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> nowCycle == $past(nowCycle) + 1'b1);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(busyUntil));

  // R3
  burst_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> busyUntil >= $past(nowCycle) + BurstLen);

endmodule

// File: rtl/bus_gap_unit.sv
module bus_gap_unit
  import bus_gap_pkg::*;
#(
  parameter int RANKS   = 4,
  parameter int TIME_W  = 32,
  parameter int T_BURST = 4,
  parameter int T_CS    = 2,
  parameter int T_WTR   = 4,
  parameter int T_CL    = 5,
  parameter int T_RTW   = 2,
  localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [RANK_W-1:0] issueRank,
  input  logic              issueWrite,
  input  logic              typeSwitch,
  output logic [TIME_W-1:0] nowCycle,
  output logic [TIME_W-1:0] busyUntil,
  output logic [RANK_W-1:0] activeRank,
  output logic              busy
);

  gapCtl_t ctl;

  bus_gap_ctrl #(.RANKS(RANKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueRank(issueRank),
    .issueWrite(issueWrite), .typeSwitch(typeSwitch), .ctl(ctl),
    .activeRank(activeRank)
  );

  bus_gap_datapath #(
    .TIME_W(TIME_W), .T_BURST(T_BURST), .T_CS(T_CS), .T_WTR(T_WTR),
    .T_CL(T_CL), .T_RTW(T_RTW)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .nowCycle(nowCycle),
    .busyUntil(busyUntil), .busy(busy)
  );

endmodule

// File: tb/bus_gap_unit_tb_top.sv
module bus_gap_unit_tb_top;

  localparam int RANKS = 4, TIME_W = 32, RANK_W = 2;
  localparam int T_BURST = 4, T_CS = 2, T_WTR = 4, T_CL = 5, T_RTW = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic issueValid = 1'b0, issueWrite = 1'b0, typeSwitch = 1'b0;
  logic [RANK_W-1:0] issueRank = '0;
  logic [TIME_W-1:0] nowCycle, busyUntil;
  logic [RANK_W-1:0] activeRank;
  logic busy;

  int checks = 0, errors = 0;
  longint mNow = 0, mBusy = 0;
  int mRank = 0;

  always #2.5 clk = ~clk;

  bus_gap_unit #(.RANKS(RANKS), .TIME_W(TIME_W), .T_BURST(T_BURST), .T_CS(T_CS),
    .T_WTR(T_WTR), .T_CL(T_CL), .T_RTW(T_RTW)) dut_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueRank(issueRank),
    .issueWrite(issueWrite), .typeSwitch(typeSwitch), .nowCycle(nowCycle),
    .busyUntil(busyUntil), .activeRank(activeRank), .busy(busy));

  always @(posedge clk) if (rstN) mNow <= mNow + 1;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Issue one burst and check the bus-free cycle and active rank afterwards.
  task automatic issue(string req, int rank, bit wr, bit sw);
    longint base, gap;
    @(negedge clk);
    issueValid = 1'b1; issueRank = RANK_W'(rank); issueWrite = wr; typeSwitch = sw;
    base = (mBusy > mNow) ? mBusy : mNow;
    if (rank != mRank)  gap = T_CS;
    else if (sw && wr)  gap = T_RTW;
    else if (sw)        gap = T_WTR + T_CL;
    else                gap = 0;
    mBusy = base + gap + T_BURST;
    mRank = rank;
    @(negedge clk);
    issueValid = 1'b0; typeSwitch = 1'b0;
    chk(req, busyUntil, mBusy);
    chk("R8", activeRank, mRank);
    chk("R9", busy, (mNow < mBusy) ? 1 : 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1", nowCycle, 0); chk("R1", busyUntil, 0);
    chk("R1", activeRank, 0); chk("R1", busy, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2", nowCycle, mNow);
    chk("R2", nowCycle, 3);
  endtask

  task automatic testSameRank();
    issue("R3", 0, 1'b0, 1'b0);
    issue("R3", 0, 1'b0, 1'b0);   // stacks on busy bus
  endtask

  task automatic testRankSwitch();
    issue("R4", 2, 1'b0, 1'b0);
    issue("R4", 1, 1'b0, 1'b0);
  endtask

  task automatic testDirection();
    issue("R6", 1, 1'b1, 1'b1);   // read-to-write same rank
    issue("R3", 1, 1'b1, 1'b0);
    issue("R5", 1, 1'b0, 1'b1);   // write-to-read same rank
  endtask

  task automatic testSwitchAndRank();
    issue("R7", 3, 1'b1, 1'b1);
    issue("R7", 0, 1'b0, 1'b1);
  endtask

  task automatic testIdleAndHold();
    repeat (40) @(negedge clk);
    chk("R9", busy, 0);
    chk("R8", busyUntil, mBusy);  // no issue: unchanged
    chk("R8", activeRank, mRank);
    issue("R10", 0, 1'b0, 1'b1);
    issue("R10", 0, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    issue("R10", 2, 1'b1, 1'b0);
    @(negedge clk);
    chk("R2", nowCycle, mNow);
  endtask

  initial begin
    fork
      begin
        testReset();
        testSameRank();
        testRankSwitch();
        testDirection();
        testSwitchAndRank();
        testIdleAndHold();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule